// File: doc/BRIEF.md
# One-Shot and Periodic Tick Timer Pair

This block holds two 32-bit tick counters behind a small memory-mapped register window. One counter is a one-shot: it counts down once, raises a single-cycle expiry pulse and then falls back to its stopped state. The other is periodic: it pulses each time its count runs out and reloads itself from its load value.

Each counter has two registers. The control register is written to start or stop the counter, and reading it returns the current load value. The remaining register is read-only and reports the live count of ticks left. A tick is one cycle in which `tick_en` is high. Prescaling is left to whatever drives `tick_en`.

The bus is a single-beat request (valid, write, address, size in bytes, data). A response follows in the next cycle. Register values are big-endian across the four byte lanes.

Top module: `tick_timer_pair`

## Requirements
- R1: The offset is the address modulo 0x40. The registers are: 0x20 one-shot control, 0x24 one-shot remaining, 0x28 periodic control, 0x2C periodic remaining. Any other offset reads as zero, ignores writes and raises no error.
- R2: Byte lane k (bits 8k+7..8k of `req_wdata` and `rsp_rdata`) carries the byte at address offset k. Offset 0 is the most significant byte of the 32-bit value.
- R3: An access to one of the four registers with `req_size` other than 4 sets `rsp_err` and returns zero read data. It changes no counter state.
- R4: Writing zero to a control register stops that counter at once, and it produces no expiry afterwards.
- R5: Writing a non-zero N to a control register cancels any pending expiry. The expiry pulse then follows exactly N ticks after the write.
- R6: Reading a control register returns its load value.
- R7: Reading a remaining register returns the ticks left before the next expiry. It returns zero while that counter is stopped.
- R8: When the one-shot expires, its load value becomes zero and `oneshot_fire` pulses high for exactly one cycle.
- R9: When the periodic counter expires, `periodic_fire` pulses for one cycle and the count reloads to N, so the counter fires every N ticks. With N=1 it fires on every tick.
- R10: After reset both counters are stopped with zero load values, and both fire outputs are low.
- R11: `rsp_valid` is high in the cycle after each request. A write in the same cycle as a tick takes priority, so the tick does not decrement the newly loaded count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One tick per cycle high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, byte lanes per R2 |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_rdata | output | 32 | Read data, byte lanes per R2 |
| rsp_err | output | 1 | Wrong access size on a counter register |
| oneshot_fire | output | 1 | One-shot expiry pulse |
| periodic_fire | output | 1 | Periodic expiry pulse |

## Verification
A corrupted remaining count shows up in the remaining register on the very next read. It also moves the fire pulse to the wrong tick, so tick-count checks expose it within one period. A load value that was cleared or kept wrongly shows in the control read-back, and for the periodic counter it also alters the spacing of the second pulse. A wrong byte order or a bad address alias shows in the first response after the access.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned WIN_BITS = 6;   // register window is 0x40 bytes

  localparam logic [WIN_BITS-1:0] OFS_ONE_CTL = 6'h20;
  localparam logic [WIN_BITS-1:0] OFS_ONE_REM = 6'h24;
  localparam logic [WIN_BITS-1:0] OFS_PER_CTL = 6'h28;
  localparam logic [WIN_BITS-1:0] OFS_PER_REM = 6'h2C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ONE_CTL,
    SEL_ONE_REM,
    SEL_PER_CTL,
    SEL_PER_REM
  } reg_sel_e;

  // bus lanes -> numeric value: lane 0 is the most significant byte
  function automatic logic [DATA_W-1:0] lanes_to_value(input logic [DATA_W-1:0] lanes);
    return {lanes[7:0], lanes[15:8], lanes[23:16], lanes[31:24]};
  endfunction

  function automatic logic [DATA_W-1:0] value_to_lanes(input logic [DATA_W-1:0] value);
    return {value[7:0], value[15:8], value[23:16], value[31:24]};
  endfunction

  // one tick applied to a running count; reload comes from the caller
  function automatic logic [DATA_W-1:0] count_after_tick(input logic [DATA_W-1:0] cur,
                                                         input logic [DATA_W-1:0] reload);
    return (cur == 1) ? reload : cur - 1'b1;
  endfunction
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  output reg_sel_e          sel,
  output logic              size_bad,
  output logic              one_we,
  output logic              per_we
);
  logic [WIN_BITS-1:0] ofs;
  logic                good;

  assign ofs = req_addr[WIN_BITS-1:0];

  always_comb begin
    unique case (ofs)
      OFS_ONE_CTL: sel = SEL_ONE_CTL;
      OFS_ONE_REM: sel = SEL_ONE_REM;
      OFS_PER_CTL: sel = SEL_PER_CTL;
      OFS_PER_REM: sel = SEL_PER_REM;
      default:     sel = SEL_NONE;
    endcase
  end

  assign size_bad = req_valid && (sel != SEL_NONE) && (req_size != 3'd4);
  assign good     = req_valid && req_write && !size_bad;
  assign one_we   = good && (sel == SEL_ONE_CTL);
  assign per_we   = good && (sel == SEL_PER_CTL);
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
  import tmr_pkg::*;
#(
  parameter bit PERIODIC = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_we,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] remain_q,
  output logic              fire
);
  logic running;
  logic last_tick;     // the tick that ends the count
  logic step;          // a tick that moves the count

  assign running   = (remain_q != '0);
  assign step      = tick && running && !load_we;
  assign last_tick = step && (remain_q == 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q   <= '0;
      remain_q <= '0;
      fire     <= 1'b0;
    end else if (load_we) begin
      load_q   <= load_val;
      remain_q <= load_val;
      fire     <= 1'b0;
    end else begin
      fire <= last_tick;
      if (step) begin
        if (PERIODIC) begin
          remain_q <= count_after_tick(remain_q, load_q);
        end else begin
          remain_q <= count_after_tick(remain_q, '0);
          if (last_tick) load_q <= '0;
        end
      end
    end
  end

  assert_load_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (remain_q == $past(load_val)) && (load_q == $past(load_val)));

  assert_stopped_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !fire);

  assert_remain_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    remain_q <= load_q);

  generate
    if (!PERIODIC) begin : g_one
      assert_oneshot_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (load_q == '0) && (remain_q == '0));
      assert_oneshot_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    end else begin : g_per
      assert_periodic_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (remain_q == load_q) && (load_q != '0));
    end
  endgenerate
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              oneshot_fire,
  output logic              periodic_fire
);
  localparam int unsigned N_CNT = 2;   // index 0 one-shot, 1 periodic

  reg_sel_e          sel;
  logic              size_bad;
  logic              one_we, per_we;
  logic [DATA_W-1:0] wr_value;
  logic [N_CNT-1:0]  we_v, fire_v;
  logic [DATA_W-1:0] load_v   [N_CNT];
  logic [DATA_W-1:0] remain_v [N_CNT];
  logic [DATA_W-1:0] rd_value;

  tmr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .sel       (sel),
    .size_bad  (size_bad),
    .one_we    (one_we),
    .per_we    (per_we)
  );

  assign wr_value = lanes_to_value(req_wdata);
  assign we_v     = {per_we, one_we};

  generate
    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
      tmr_count_unit #(.PERIODIC(i == 1)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .load_we  (we_v[i]),
        .load_val (wr_value),
        .load_q   (load_v[i]),
        .remain_q (remain_v[i]),
        .fire     (fire_v[i])
      );
    end
  endgenerate

  assign oneshot_fire  = fire_v[0];
  assign periodic_fire = fire_v[1];

  always_comb begin
    unique case (sel)
      SEL_ONE_CTL: rd_value = load_v[0];
      SEL_ONE_REM: rd_value = remain_v[0];
      SEL_PER_CTL: rd_value = load_v[1];
      SEL_PER_REM: rd_value = remain_v[1];
      default:     rd_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= size_bad;
      rsp_rdata <= (req_valid && !req_write && !size_bad) ? value_to_lanes(rd_value) : '0;
    end
  end

  assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_err_zero_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0) && rsp_valid);

  assert_err_keeps_periodic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $stable(load_v[1]));

  assert_err_keeps_oneshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && !oneshot_fire) |-> $stable(load_v[0]));
endmodule

// File: tb/tick_timer_pair_test.sv
`timescale 1ns/1ps
module tick_timer_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, oneshot_fire, periodic_fire;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  tick_timer_pair #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .oneshot_fire(oneshot_fire), .periodic_fire(periodic_fire)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [2:0]  size;
    logic [31:0] val;    // write value or tick count
    logic [31:0] exp;    // expected read value
    logic [3:0]  n_one;  // expected one-shot pulses
    logic [3:0]  n_per;  // expected periodic pulses
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{OP_WR, 8'h20, 3'd4, 32'd5,  32'd0, 4'd0, 4'd0, 1'b0, 4'd5},  // R5 start one-shot
    '{OP_RD, 8'h20, 3'd4, 32'd0,  32'd5, 4'd0, 4'd0, 1'b0, 4'd6},  // R6
    '{OP_RD, 8'h24, 3'd4, 32'd0,  32'd5, 4'd0, 4'd0, 1'b0, 4'd7},  // R7
    '{OP_TK, 8'h00, 3'd4, 32'd3,  32'd0, 4'd0, 4'd0, 1'b0, 4'd5},  // R5 not yet
    '{OP_RD, 8'h24, 3'd4, 32'd0,  32'd2, 4'd0, 4'd0, 1'b0, 4'd7},  // R7
    '{OP_TK, 8'h00, 3'd4, 32'd2,  32'd0, 4'd1, 4'd0, 1'b0, 4'd8},  // R8 fires once
    '{OP_RD, 8'h20, 3'd4, 32'd0,  32'd0, 4'd0, 4'd0, 1'b0, 4'd8},  // R8 load cleared
    '{OP_RD, 8'h24, 3'd4, 32'd0,  32'd0, 4'd0, 4'd0, 1'b0, 4'd7},  // R7 stopped
    '{OP_WR, 8'h28, 3'd4, 32'd4,  32'd0, 4'd0, 4'd0, 1'b0, 4'd9},  // R9
    '{OP_TK, 8'h00, 3'd4, 32'd10, 32'd0, 4'd0, 4'd2, 1'b0, 4'd9},  // R9 two periods
    '{OP_RD, 8'h2C, 3'd4, 32'd0,  32'd2, 4'd0, 4'd0, 1'b0, 4'd7},  // R7
    '{OP_RD, 8'h28, 3'd4, 32'd0,  32'd4, 4'd0, 4'd0, 1'b0, 4'd6},  // R6
    '{OP_WR, 8'h28, 3'd4, 32'd0,  32'd0, 4'd0, 4'd0, 1'b0, 4'd4},  // R4 stop
    '{OP_TK, 8'h00, 3'd4, 32'd10, 32'd0, 4'd0, 4'd0, 1'b0, 4'd4},  // R4 silent
    '{OP_RD, 8'h2C, 3'd4, 32'd0,  32'd0, 4'd0, 4'd0, 1'b0, 4'd4},  // R4
    '{OP_RD, 8'h20, 3'd2, 32'd0,  32'd0, 4'd0, 4'd0, 1'b1, 4'd3},  // R3 bad read
    '{OP_WR, 8'h20, 3'd2, 32'd7,  32'd0, 4'd0, 4'd0, 1'b1, 4'd3},  // R3 bad write
    '{OP_RD, 8'h20, 3'd4, 32'd0,  32'd0, 4'd0, 4'd0, 1'b0, 4'd3},  // R3 unchanged
    '{OP_WR, 8'h60, 3'd4, 32'd3,  32'd0, 4'd0, 4'd0, 1'b0, 4'd1},  // R1 alias
    '{OP_RD, 8'h20, 3'd4, 32'd0,  32'd3, 4'd0, 4'd0, 1'b0, 4'd1},  // R1
    '{OP_RD, 8'h64, 3'd4, 32'd0,  32'd3, 4'd0, 4'd0, 1'b0, 4'd1},  // R1
    '{OP_TK, 8'h00, 3'd4, 32'd2,  32'd0, 4'd0, 4'd0, 1'b0, 4'd5},  // R5
    '{OP_WR, 8'h20, 3'd4, 32'd5,  32'd0, 4'd0, 4'd0, 1'b0, 4'd5},  // R5 reload
    '{OP_TK, 8'h00, 3'd4, 32'd4,  32'd0, 4'd0, 4'd0, 1'b0, 4'd5},  // R5 cancelled
    '{OP_RD, 8'h24, 3'd4, 32'd0,  32'd1, 4'd0, 4'd0, 1'b0, 4'd7},  // R7
    '{OP_TK, 8'h00, 3'd4, 32'd1,  32'd0, 4'd1, 4'd0, 1'b0, 4'd5},  // R5
    '{OP_WR, 8'h20, 3'd4, 32'd9,  32'd0, 4'd0, 4'd0, 1'b0, 4'd4},  // R4
    '{OP_WR, 8'h20, 3'd4, 32'd0,  32'd0, 4'd0, 4'd0, 1'b0, 4'd4},  // R4 cancel
    '{OP_TK, 8'h00, 3'd4, 32'd12, 32'd0, 4'd0, 4'd0, 1'b0, 4'd4},  // R4
    '{OP_RD, 8'hA8, 3'd4, 32'd0,  32'd0, 4'd0, 4'd0, 1'b0, 4'd1}   // R1
  };

  function automatic logic [31:0] to_lanes(input logic [31:0] v);
    logic [31:0] l;
    for (int k = 0; k < 4; k++) l[8*k +: 8] = v[8*(3-k) +: 8];
    return l;
  endfunction

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [2:0] sz,
                        input logic [31:0] lanes, output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = lanes;
    @(negedge clk);
    req_valid = 1'b0;
    check(11, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic ticks(input int n, output int c_one, output int c_per);
    c_one = 0; c_per = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      c_one += oneshot_fire; c_per += periodic_fire;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic er;
    int c1, c2;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(10, "oneshot_fire in reset", {31'd0, oneshot_fire}, 32'd0);
    check(10, "periodic_fire in reset", {31'd0, periodic_fire}, 32'd0);
    rst_n = 1'b1;
    access(1'b0, 8'h20, 3'd4, 32'd0, rd, er); check(10, "one-shot load", rd, 32'd0);
    access(1'b0, 8'h28, 3'd4, 32'd0, rd, er); check(10, "periodic load", rd, 32'd0);
    ticks(5, c1, c2);
    check(10, "no pulses after reset", c1 + c2, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      if (v.op == OP_TK) begin
        ticks(int'(v.val), c1, c2);
        check(int'(v.req), $sformatf("vec %0d one-shot pulses", i), c1, {28'd0, v.n_one});
        check(int'(v.req), $sformatf("vec %0d periodic pulses", i), c2, {28'd0, v.n_per});
      end else begin
        access(v.op == OP_WR, v.addr, v.size, to_lanes(v.val), rd, er);
        check(int'(v.req), $sformatf("vec %0d err", i), {31'd0, er}, {31'd0, v.err});
        if (v.op == OP_RD)
          check(int'(v.req), $sformatf("vec %0d rdata", i), rd, to_lanes(v.exp));
      end
    end

    // R2 raw lane order
    access(1'b1, 8'h28, 3'd4, 32'h04030201, rd, er);
    access(1'b0, 8'h28, 3'd4, 32'd0, rd, er);
    check(2, "raw lanes", rd, 32'h04030201);
    access(1'b1, 8'h28, 3'd4, 32'd0, rd, er);

    // R1 unmapped offset
    access(1'b1, 8'h30, 3'd2, 32'hFFFFFFFF, rd, er);
    check(1, "unmapped write err", {31'd0, er}, 32'd0);
    access(1'b0, 8'h30, 3'd4, 32'd0, rd, er);
    check(1, "unmapped read", rd, 32'd0);

    // R9 period of one tick
    access(1'b1, 8'h28, 3'd4, to_lanes(32'd1), rd, er);
    ticks(3, c1, c2);
    check(9, "N=1 pulses", c2, 32'd3);
    access(1'b1, 8'h28, 3'd4, 32'd0, rd, er);

    // R11 write beats a concurrent tick
    @(negedge clk);
    tick_en = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h20;
    req_size = 3'd4; req_wdata = to_lanes(32'd2);
    @(negedge clk);
    tick_en = 1'b0; req_valid = 1'b0;
    access(1'b0, 8'h24, 3'd4, 32'd0, rd, er);
    check(11, "remaining after write+tick", rd, to_lanes(32'd2));
    ticks(2, c1, c2);
    check(11, "fires after full count", c1, 32'd1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule